// File: doc/BRIEF.md
# Half-word result packing unit

This block collects 16-bit conversion results and assembles them into 32-bit words. A two-bit mode input picks one of four layouts. In the two single-half layouts, every result produces a word on its own. In these words one half carries the result and the other half is zero. In the two dual layouts, a pair of results fills one word. The first result of the pair goes either to the upper half or to the lower half, and the word completes on the write to the opposite half.

When simultaneous packing is enabled in a dual layout, each result carries a master/slave tag. The master result always lands in the first-position half and the slave result in the other half. The slave write completes the word.

The unit also provides the following outputs:
- a status bit that shows which half the next result will be written to;
- a data-ready flag that stays set until the consumer acknowledges a read;
- a one-cycle completion interrupt, gated by an enable.

The 32-bit word leaves with a one-cycle valid strobe, toward a FIFO or a read register.

Top module: `half_pack_unit`

## Requirements
- R1: After synchronous reset, word_valid, data_ready and done_irq are 0, word_data is 0 and next_upper is 1.
- R2: In mode 0 (upper only), each accepted result appears in word_data[31:16], with word_data[15:0] = 0. word_valid pulses one cycle after the result is accepted.
- R3: In mode 1 (lower only), each accepted result appears in word_data[15:0], with word_data[31:16] = 0. Every result completes a word.
- R4: In mode 2 (upper first), the earlier result of a pair goes to bits [31:16] and the later result to bits [15:0]. The word completes only on the lower-half write.
- R5: In mode 3 (lower first), the earlier result goes to bits [15:0] and the later result to bits [31:16]. The word completes only on the upper-half write.
- R6: With simul_en = 1 in mode 2 or 3, a result with res_is_slave = 0 (master) goes to the first-position half and a result with res_is_slave = 1 goes to the other half. The slave write completes the word.
- R7: next_upper shows the half that the next result will be written to (1 = upper, 0 = lower). It is updated one cycle after each accepted result.
- R8: data_ready is set when a word completes and cleared by rd_ack. If a completion and rd_ack occur in the same cycle, the flag stays set.
- R9: done_irq pulses together with word_valid only when irq_en was 1 at the completing write. With irq_en = 0 it stays 0.
- R10: A change of pack_mode returns the half pointer to the first position of the new mode: upper for modes 0 and 2, lower for modes 1 and 3. next_upper shows this one cycle after the change.
- R11: With simul_en = 0, res_is_slave has no effect on where a result is placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pack_mode | input | 2 | 0 upper only, 1 lower only, 2 upper first, 3 lower first |
| simul_en | input | 1 | Simultaneous packing: placement by master/slave tag |
| irq_en | input | 1 | Enable for the completion interrupt |
| res_valid | input | 1 | A result is presented this cycle |
| res_data | input | RES_W | Conversion result |
| res_is_slave | input | 1 | Result comes from the slave converter |
| rd_ack | input | 1 | Consumer has read the word; clears data_ready |
| word_data | output | 2*RES_W | Last completed packed word |
| word_valid | output | 1 | One-cycle strobe: word_data was just completed |
| data_ready | output | 1 | A completed word is waiting to be read |
| next_upper | output | 1 | Half that receives the next result (1 = upper) |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
The following outputs are due one clock edge after the stimulus that caused them:
- word_data, word_valid, data_ready and done_irq, after the completing result is accepted;
- next_upper, after an accepted result or after a mode change.

The driver presents each result for a single cycle, with the inputs changed on the falling edge. A monitor samples on the next falling edge. It pops the expected word and interrupt flag from a scoreboard queue each time word_valid is seen, and reports any strobe for which no word was queued. Status checks on next_upper and data_ready are made on the falling edge right after the edge that updates them.

// File: rtl/half_pack_pkg.sv
package half_pack_pkg;

  typedef enum logic [1:0] {
    PK_UPPER_ONLY  = 2'd0,
    PK_LOWER_ONLY  = 2'd1,
    PK_UPPER_FIRST = 2'd2,
    PK_LOWER_FIRST = 2'd3
  } pack_mode_e;

  // first-position half of a mode: upper for even codes, lower for odd codes
  function automatic logic first_is_upper(input logic [1:0] mode);
    return ~mode[0];
  endfunction

  // modes 0 and 1 complete a word on every result
  function automatic logic is_single_half(input logic [1:0] mode);
    return ~mode[1];
  endfunction

endpackage

// File: rtl/hp_mode_track.sv
module hp_mode_track (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  output logic       mode_changed
);
  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'd0;
    else     prev_q <= mode;
  end

  assign mode_changed = (mode != prev_q);
endmodule

// File: rtl/hp_lane_sel.sv
module hp_lane_sel
  import half_pack_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       simul_en,
  input  logic       res_is_slave,
  input  logic       ptr_upper_q,
  input  logic       mode_changed,
  output logic       tgt_upper,
  output logic       completes,
  output logic       single,
  output logic       ptr_after
);
  logic first_up;
  logic eff_ptr;

  always_comb begin
    first_up = first_is_upper(mode);
    single   = is_single_half(mode);
    eff_ptr  = mode_changed ? first_up : ptr_upper_q;
    if (single) begin
      tgt_upper = first_up;
      completes = 1'b1;
    end else begin
      if (simul_en) tgt_upper = res_is_slave ? ~first_up : first_up;
      else          tgt_upper = eff_ptr;
      completes = (tgt_upper != first_up);
    end
    ptr_after = completes ? first_up : ~first_up;
  end
endmodule

// File: rtl/hp_word_asm.sv
module hp_word_asm #(
  parameter int RES_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_data,
  input  logic               tgt_upper,
  input  logic               completes,
  input  logic               single,
  output logic [2*RES_W-1:0] word_data,
  output logic               word_valid
);
  localparam int WORD_W = 2 * RES_W;

  logic [RES_W-1:0]  hold_q;
  logic [RES_W-1:0]  other_half;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;

  assign other_half = single ? '0 : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= res_valid && completes;
      if (res_valid && !completes) hold_q <= res_data;
      if (res_valid && completes) begin
        if (tgt_upper) word_q <= {res_data, other_half};
        else           word_q <= {other_half, res_data};
      end
    end
  end

  assign word_data  = word_q;
  assign word_valid = valid_q;
endmodule

// File: rtl/hp_flag_ctl.sv
module hp_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic rd_ack,
  input  logic irq_en,
  output logic data_ready,
  output logic done_irq
);
  logic ready_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire && irq_en;
      if (fire)        ready_q <= 1'b1;
      else if (rd_ack) ready_q <= 1'b0;
    end
  end

  assign data_ready = ready_q;
  assign done_irq   = irq_q;
endmodule

// File: rtl/half_pack_unit.sv
module half_pack_unit #(
  parameter int RES_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         pack_mode,
  input  logic               simul_en,
  input  logic               irq_en,
  input  logic               res_valid,
  input  logic [RES_W-1:0]   res_data,
  input  logic               res_is_slave,
  input  logic               rd_ack,
  output logic [2*RES_W-1:0] word_data,
  output logic               word_valid,
  output logic               data_ready,
  output logic               next_upper,
  output logic               done_irq
);
  import half_pack_pkg::*;

  logic mode_changed;
  logic ptr_upper_q;
  logic tgt_upper, completes, single, ptr_after;

  hp_mode_track u_mode (
    .clk(clk), .rst(rst), .mode(pack_mode), .mode_changed(mode_changed)
  );

  hp_lane_sel u_lane (
    .mode(pack_mode), .simul_en(simul_en), .res_is_slave(res_is_slave),
    .ptr_upper_q(ptr_upper_q), .mode_changed(mode_changed),
    .tgt_upper(tgt_upper), .completes(completes), .single(single),
    .ptr_after(ptr_after)
  );

  always_ff @(posedge clk) begin
    if (rst)               ptr_upper_q <= 1'b1;
    else if (res_valid)    ptr_upper_q <= ptr_after;
    else if (mode_changed) ptr_upper_q <= first_is_upper(pack_mode);
  end

  assign next_upper = ptr_upper_q;

  hp_word_asm #(.RES_W(RES_W)) u_asm (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .tgt_upper(tgt_upper), .completes(completes), .single(single),
    .word_data(word_data), .word_valid(word_valid)
  );

  hp_flag_ctl u_flags (
    .clk(clk), .rst(rst), .fire(res_valid && completes), .rd_ack(rd_ack),
    .irq_en(irq_en), .data_ready(data_ready), .done_irq(done_irq)
  );
endmodule

// File: rtl/half_pack_unit_chk.sv
module half_pack_unit_chk #(
  parameter int RES_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         pack_mode,
  input logic               simul_en,
  input logic               irq_en,
  input logic               res_valid,
  input logic [RES_W-1:0]   res_data,
  input logic               res_is_slave,
  input logic               rd_ack,
  input logic [2*RES_W-1:0] word_data,
  input logic               word_valid,
  input logic               data_ready,
  input logic               next_upper,
  input logic               done_irq
);
  // R2
  upper_only_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && pack_mode == 2'd0) |=>
      (word_valid && word_data[RES_W-1:0] == '0 && word_data[2*RES_W-1:RES_W] == $past(res_data)));

  // R3
  lower_only_zero_high_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && pack_mode == 2'd1) |=>
      (word_valid && word_data[2*RES_W-1:RES_W] == '0 && word_data[RES_W-1:0] == $past(res_data)));

  // R4
  upper_first_close_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && pack_mode == 2'd2 && !simul_en && !next_upper && $stable(pack_mode)) |=>
      (word_valid && word_data[RES_W-1:0] == $past(res_data)));

  // R6
  slave_second_half_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && simul_en && pack_mode == 2'd2 && res_is_slave) |=>
      (word_valid && word_data[RES_W-1:0] == $past(res_data)));

  // R8
  ready_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> data_ready);

  // R8
  ack_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !res_valid) |=> !data_ready);

  // R9
  irq_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> word_valid);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !done_irq);

  // R10
  mode_change_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (pack_mode != $past(pack_mode) && !res_valid) |=> (next_upper == !$past(pack_mode[0])));
endmodule

bind half_pack_unit half_pack_unit_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/half_pack_unit_bench.sv
`timescale 1ns/1ps
module half_pack_unit_bench;
  localparam int RES_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        pack_mode = 2'd0;
  logic              simul_en = 1'b0;
  logic              irq_en = 1'b1;
  logic              res_valid = 1'b0;
  logic [RES_W-1:0]  res_data = '0;
  logic              res_is_slave = 1'b0;
  logic              rd_ack = 1'b0;
  logic [31:0]       word_data;
  logic              word_valid, data_ready, next_upper, done_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_w[$];
  logic        exp_i[$];

  always #10 clk = ~clk;

  half_pack_unit #(.RES_W(RES_W)) u_half_pack_unit (
    .clk(clk), .rst(rst), .pack_mode(pack_mode), .simul_en(simul_en),
    .irq_en(irq_en), .res_valid(res_valid), .res_data(res_data),
    .res_is_slave(res_is_slave), .rd_ack(rd_ack), .word_data(word_data),
    .word_valid(word_valid), .data_ready(data_ready),
    .next_upper(next_upper), .done_irq(done_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] w, input logic irq);
    exp_w.push_back(w);
    exp_i.push_back(irq);
  endtask

  task automatic send(input logic [15:0] d, input logic slave);
    res_valid    = 1'b1;
    res_data     = d;
    res_is_slave = slave;
    @(negedge clk);
    res_valid    = 1'b0;
    res_is_slave = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    pack_mode = m;
    @(negedge clk);
  endtask

  // monitor: compares every strobed word with the scoreboard head
  always @(negedge clk) begin
    if (!rst && word_valid) begin
      if (exp_w.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2-R6 unexpected word: actual %h expected none", word_data);
      end else begin
        logic [31:0] w;
        logic        i;
        w = exp_w.pop_front();
        i = exp_i.pop_front();
        chk("R2/R3/R4/R5/R6 word", word_data, w);
        chk("R9 done_irq", {31'd0, done_irq}, {31'd0, i});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 word_valid", {31'd0, word_valid}, 32'd0);
    chk("R1 data_ready", {31'd0, data_ready}, 32'd0);
    chk("R1 done_irq", {31'd0, done_irq}, 32'd0);
    chk("R1 next_upper", {31'd0, next_upper}, 32'd1);
    chk("R1 word_data", word_data, 32'd0);

    // R2 upper only
    expect_word(32'h1234_0000, 1'b1); send(16'h1234, 1'b0);
    chk("R7 next_upper mode0", {31'd0, next_upper}, 32'd1);
    expect_word(32'hABCD_0000, 1'b1); send(16'hABCD, 1'b0);
    // R8 ready and clear
    chk("R8 ready set", {31'd0, data_ready}, 32'd1);
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    chk("R8 ready cleared", {31'd0, data_ready}, 32'd0);

    // R3 lower only
    set_mode(2'd1);
    chk("R10 mode1 first lower", {31'd0, next_upper}, 32'd0);
    expect_word(32'h0000_5555, 1'b1); send(16'h5555, 1'b0);

    // R4 upper first
    set_mode(2'd2);
    chk("R10 mode2 first upper", {31'd0, next_upper}, 32'd1);
    send(16'h1111, 1'b0);
    chk("R7 next lower", {31'd0, next_upper}, 32'd0);
    chk("R4 no word after first", {31'd0, word_valid}, 32'd0);
    expect_word(32'h1111_2222, 1'b1); send(16'h2222, 1'b0);
    chk("R7 back to upper", {31'd0, next_upper}, 32'd1);

    // R5 lower first
    set_mode(2'd3);
    chk("R10 mode3 first lower", {31'd0, next_upper}, 32'd0);
    send(16'h3333, 1'b0);
    chk("R7 next upper mode3", {31'd0, next_upper}, 32'd1);
    expect_word(32'h4444_3333, 1'b1); send(16'h4444, 1'b0);

    // R11 tag ignored with simul off
    set_mode(2'd2);
    send(16'h0A0A, 1'b1);
    chk("R11 tag ignored pointer", {31'd0, next_upper}, 32'd0);
    expect_word(32'h0A0A_0B0B, 1'b1); send(16'h0B0B, 1'b0);

    // R6 simultaneous placement
    simul_en = 1'b1;
    send(16'h6666, 1'b0);
    chk("R6 master first", {31'd0, next_upper}, 32'd0);
    expect_word(32'h6666_7777, 1'b1); send(16'h7777, 1'b1);
    set_mode(2'd3);
    send(16'h8888, 1'b0);
    expect_word(32'h9999_8888, 1'b1); send(16'h9999, 1'b1);
    simul_en = 1'b0;

    // R9 interrupt disabled
    irq_en = 1'b0;
    set_mode(2'd0);
    expect_word(32'h0101_0000, 1'b0); send(16'h0101, 1'b0);
    irq_en = 1'b1;

    // R10 mode change mid-pair resets pointer
    set_mode(2'd2);
    send(16'hAAAA, 1'b0);
    chk("R10 partial pointer", {31'd0, next_upper}, 32'd0);
    set_mode(2'd3);
    set_mode(2'd2);
    chk("R10 pointer reset", {31'd0, next_upper}, 32'd1);
    send(16'hC0C0, 1'b0);
    expect_word(32'hC0C0_D0D0, 1'b1); send(16'hD0D0, 1'b0);

    // R8 completion beats acknowledge
    set_mode(2'd1);
    rd_ack = 1'b1;
    expect_word(32'h0000_0F0F, 1'b1); send(16'h0F0F, 1'b0);
    rd_ack = 1'b0;
    chk("R8 set wins over ack", {31'd0, data_ready}, 32'd1);

    repeat (3) @(negedge clk);
    chk("R2-R6 scoreboard drained", exp_w.size(), 32'd0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule